// File: doc/BRIEF.md
# SCSI Initiator Command Register Decoder

This block is the byte-wide host-facing register front end of a simple SCSI initiator controller. The host reaches sixteen byte registers through a 4-bit address. Each address has a read image and a write image held separately, so a location can return one thing while it holds what was last written. Command bytes written to the command location are decoded on the spot. The block then updates the status, interrupt-cause and sequence-step registers and drives a single level-sensitive interrupt line back to the host.

Selection and transfer-information commands are not carried out here. They leave the block as one-cycle strobes to the neighbouring bus-phase and data-movement logic. That logic reports back through a completion port, which loads the status phase bits, the interrupt cause and the sequence step, and raises the interrupt. Bus phases, the data buffer and DMA data movement all belong to other blocks.

Register locations used by software: 0 counter low, 1 counter mid, 2 data port (not held here), 3 command, 4 status, 5 interrupt cause, 6 sequence step, 7 flags, 8 config-1, 14 counter high. Locations 8 and 11 to 15 read back what was written. Locations 4 to 7, 9 and 10 keep writes in the write image only.

Top module: `scsi_cmd_regs`

## Requirements
- R1: After reset every readable location returns 0x00, except config-1 (address 8), which returns 0x07, and counter high (address 14), which returns 0x04. The interrupt output and the DMA-mode output are low.
- R2: A command byte with bit 7 set drives dma_mode high and copies the last written counter low and mid values into their readable images. A command byte with bit 7 clear drives dma_mode low and leaves the readable counter unchanged. Bits 6:0 are the opcode in both cases.
- R3: A write to counter low (address 0) or mid (address 1) leaves that location's readable value unchanged and clears status bit 4 (terminal count).
- R4: A host read of address 5 returns the cause value held before the read. The same read sets the cause to 0x00, clears status bits 7 and 4, sets the sequence step to 4 and lowers the interrupt output.
- R5: Opcode 0x03 (bus reset) loads cause 0x80. It raises the interrupt only when bit 6 of the written config-1 value is clear.
- R6: Opcode 0x01 (flush) loads cause 0x08 and clears the sequence step and flags, without touching the interrupt.
- R7: Opcode 0x12 (message accepted) loads cause 0x20, clears the sequence step and flags, and raises the interrupt.
- R8: Opcode 0x02 (chip reset) returns every register, including the write images and dma_mode, to its R1 value, and the interrupt output is low from the next cycle.
- R9: Opcode 0x10 pulses xfer_go for one cycle, starting the cycle after the write. Opcodes 0x41, 0x42 and 0x43 pulse sel_go for one cycle with sel_kind equal to opcode bits 1:0. No other opcode pulses either strobe.
- R10: A completion pulse loads status bits 6:0 from done_stat, the cause from done_intr and the sequence step from done_seq, and raises the interrupt. It overrides a same-cycle host access for the registers it loads, but a chip reset overrides it.
- R11: Opcodes 0x00, 0x1A and every undefined opcode change nothing but the command register's readable value, plus the R2 effects.
- R12: Opcode 0x11 sets status bits 2:0 to 7, loads cause 0x08, sets flags to 2 and raises the interrupt. Opcode 0x18 sets status bits 6:0 to 0x10, loads cause 0x08 and clears the sequence step. Opcode 0x44 clears the cause.
- R13: The interrupt output always equals status bit 7 as the host reads it. Raising it when it is already set changes nothing.
- R14: Writes to locations 8 and 11 to 15 read back as written. Writes to 2, 4 to 7, 9 and 10 leave their readable values unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe (ignored while host_wr is high) |
| host_addr | input | 4 | Register address |
| host_wdata | input | 8 | Write data |
| done_valid | input | 1 | Completion pulse from neighbouring logic |
| done_stat | input | 7 | Status bits 6:0 to load on completion |
| done_intr | input | 8 | Interrupt cause to load on completion |
| done_seq | input | 3 | Sequence step to load on completion |
| host_rdata | output | 8 | Read data, valid the cycle after host_rd |
| irq | output | 1 | Level interrupt to the host |
| dma_mode | output | 1 | Last command carried the DMA bit |
| xfer_go | output | 1 | One-cycle transfer-information strobe |
| sel_go | output | 1 | One-cycle selection strobe |
| sel_kind | output | 2 | Selection variant, valid with sel_go |

## Verification
The hardest state to reach is the one in which each opcode's effect can be told apart from doing nothing. At reset the flags, cause and sequence step are all zero and the interrupt is low, so a decoder that ignored most opcodes would look correct. Before every opcode, the bench therefore builds a distinctive preload through the ports: a chip reset, a command-complete-sequence command to put flags at 2, and a completion pulse that sets the cause, the sequence step, the terminal-count bit and the interrupt. It then sweeps all 128 opcodes over that preload and reads back command, status, step, flags and cause, in an order that keeps the clearing read of the cause last.

// File: rtl/scsi_cmd_pkg.sv
package scsi_cmd_pkg;

  // Register locations whose meaning the host software decodes
  localparam int unsigned LOC_CNT_LO = 0;
  localparam int unsigned LOC_CNT_MID = 1;
  localparam int unsigned LOC_CMD = 3;
  localparam int unsigned LOC_STAT = 4;
  localparam int unsigned LOC_CAUSE = 5;
  localparam int unsigned LOC_STEP = 6;
  localparam int unsigned LOC_FLAGS = 7;
  localparam int unsigned LOC_CFG1 = 8;
  localparam int unsigned LOC_CNT_HI = 14;
  localparam int unsigned LOC_MIRROR_LO = 11;

  localparam logic [7:0] CFG1_INIT = 8'h07;
  localparam logic [7:0] CNT_HI_INIT = 8'h04;

  localparam int unsigned STAT_IRQ_BIT = 7;
  localparam int unsigned STAT_TC_BIT = 4;
  localparam int unsigned CFG1_QUIET_BIT = 6;

  localparam logic [7:0] CAUSE_FUNC_DONE = 8'h08;
  localparam logic [7:0] CAUSE_DISCONNECT = 8'h20;
  localparam logic [7:0] CAUSE_BUS_RESET = 8'h80;

  typedef enum logic [6:0] {
    OP_NOP       = 7'h00,
    OP_FLUSH     = 7'h01,
    OP_CHIP_RST  = 7'h02,
    OP_BUS_RST   = 7'h03,
    OP_XFER      = 7'h10,
    OP_CMPL_SEQ  = 7'h11,
    OP_MSG_OK    = 7'h12,
    OP_PAD       = 7'h18,
    OP_ATN       = 7'h1A,
    OP_SEL       = 7'h41,
    OP_SEL_ATN   = 7'h42,
    OP_SEL_STOP  = 7'h43,
    OP_EN_SEL    = 7'h44
  } opcode_e;

  typedef struct packed {
    logic flush;
    logic chip_rst;
    logic bus_rst;
    logic xfer;
    logic cmpl_seq;
    logic msg_ok;
    logic pad;
    logic sel;
    logic en_sel;
  } action_t;

endpackage

// File: rtl/scsi_cmd_decode.sv
module scsi_cmd_decode
  import scsi_cmd_pkg::*;
(
  input  logic [6:0] opcode,
  output action_t    act
);

  always_comb begin
    act = '0;
    case (opcode)
      OP_FLUSH:    act.flush = 1'b1;
      OP_CHIP_RST: act.chip_rst = 1'b1;
      OP_BUS_RST:  act.bus_rst = 1'b1;
      OP_XFER:     act.xfer = 1'b1;
      OP_CMPL_SEQ: act.cmpl_seq = 1'b1;
      OP_MSG_OK:   act.msg_ok = 1'b1;
      OP_PAD:      act.pad = 1'b1;
      OP_SEL, OP_SEL_ATN, OP_SEL_STOP: act.sel = 1'b1;
      OP_EN_SEL:   act.en_sel = 1'b1;
      default:     act = '0;
    endcase
  end

endmodule

// File: rtl/scsi_reg_bank.sv
module scsi_reg_bank
  import scsi_cmd_pkg::*;
#(
  parameter int unsigned DW   = 8,
  parameter int unsigned AW   = 4,
  parameter int unsigned SEQW = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          host_wr,
  input  logic          host_rd,
  input  logic [AW-1:0] host_addr,
  input  logic [DW-1:0] host_wdata,
  input  logic          cmd_go,
  input  action_t       act,
  input  logic          done_valid,
  input  logic [DW-2:0] done_stat,
  input  logic [DW-1:0] done_intr,
  input  logic [SEQW-1:0] done_seq,
  output logic [DW-1:0] host_rdata,
  output logic          irq,
  output logic          dma_mode
);

  localparam int unsigned NREG = 1 << AW;
  localparam logic [AW-1:0] A_LO    = AW'(LOC_CNT_LO);
  localparam logic [AW-1:0] A_MID   = AW'(LOC_CNT_MID);
  localparam logic [AW-1:0] A_CMD   = AW'(LOC_CMD);
  localparam logic [AW-1:0] A_CFG1  = AW'(LOC_CFG1);
  localparam logic [AW-1:0] A_CAUSE = AW'(LOC_CAUSE);
  localparam logic [AW-1:0] A_MIRR  = AW'(LOC_MIRROR_LO);

  logic [DW-1:0] rimg [NREG];
  logic [DW-1:0] wimg [NREG];

  logic rd_go;
  logic mirror_wr;
  logic full_clear;

  assign rd_go      = host_rd && !host_wr;
  assign mirror_wr  = host_wr && (host_addr == A_CFG1 || host_addr >= A_MIRR);
  assign full_clear = rst || (cmd_go && act.chip_rst);

  always_ff @(posedge clk) begin
    if (full_clear) begin
      for (int i = 0; i < NREG; i++) begin
        rimg[i] <= '0;
        wimg[i] <= '0;
      end
      rimg[LOC_CFG1]   <= DW'(CFG1_INIT);
      rimg[LOC_CNT_HI] <= DW'(CNT_HI_INIT);
      irq      <= 1'b0;
      dma_mode <= 1'b0;
      if (rst) host_rdata <= '0;
    end else begin
      // host read, the cause location clears on read
      if (rd_go) begin
        host_rdata <= rimg[host_addr];
        if (host_addr == A_CAUSE) begin
          rimg[LOC_CAUSE] <= '0;
          rimg[LOC_STAT][STAT_TC_BIT]  <= 1'b0;
          rimg[LOC_STAT][STAT_IRQ_BIT] <= 1'b0;
          rimg[LOC_STEP] <= DW'(4);
          irq <= 1'b0;
        end
      end
      // host write
      if (host_wr) begin
        wimg[host_addr] <= host_wdata;
        if (mirror_wr) rimg[host_addr] <= host_wdata;
        if (host_addr == A_LO || host_addr == A_MID)
          rimg[LOC_STAT][STAT_TC_BIT] <= 1'b0;
      end
      // command execution
      if (cmd_go) begin
        rimg[LOC_CMD] <= host_wdata;
        dma_mode <= host_wdata[DW-1];
        if (host_wdata[DW-1]) begin
          rimg[LOC_CNT_LO]  <= wimg[LOC_CNT_LO];
          rimg[LOC_CNT_MID] <= wimg[LOC_CNT_MID];
        end
        if (act.flush) begin
          rimg[LOC_CAUSE] <= DW'(CAUSE_FUNC_DONE);
          rimg[LOC_STEP]  <= '0;
          rimg[LOC_FLAGS] <= '0;
        end
        if (act.bus_rst) begin
          rimg[LOC_CAUSE] <= DW'(CAUSE_BUS_RESET);
          if (!wimg[LOC_CFG1][CFG1_QUIET_BIT]) begin
            rimg[LOC_STAT][STAT_IRQ_BIT] <= 1'b1;
            irq <= 1'b1;
          end
        end
        if (act.cmpl_seq) begin
          rimg[LOC_STAT][2:0] <= 3'b111;
          rimg[LOC_STAT][STAT_IRQ_BIT] <= 1'b1;
          rimg[LOC_CAUSE] <= DW'(CAUSE_FUNC_DONE);
          rimg[LOC_FLAGS] <= DW'(2);
          irq <= 1'b1;
        end
        if (act.msg_ok) begin
          rimg[LOC_CAUSE] <= DW'(CAUSE_DISCONNECT);
          rimg[LOC_STEP]  <= '0;
          rimg[LOC_FLAGS] <= '0;
          rimg[LOC_STAT][STAT_IRQ_BIT] <= 1'b1;
          irq <= 1'b1;
        end
        if (act.pad) begin
          rimg[LOC_STAT][DW-2:0] <= (DW-1)'(8'h10);
          rimg[LOC_CAUSE] <= DW'(CAUSE_FUNC_DONE);
          rimg[LOC_STEP]  <= '0;
        end
        if (act.en_sel) rimg[LOC_CAUSE] <= '0;
      end
      // completion report from neighbouring logic overrides host effects
      if (done_valid) begin
        rimg[LOC_STAT][DW-2:0] <= done_stat;
        rimg[LOC_STAT][STAT_IRQ_BIT] <= 1'b1;
        rimg[LOC_CAUSE] <= done_intr;
        rimg[LOC_STEP]  <= DW'(done_seq);
        irq <= 1'b1;
      end
    end
  end

  // R4: a read of the cause location clears it and drops the line
  p_cause_read_clears_r4: assert property (@(posedge clk) disable iff (rst)
    (rd_go && host_addr == A_CAUSE && !done_valid)
      |=> (rimg[LOC_CAUSE] == '0 && !irq && rimg[LOC_STEP] == DW'(4)));

  // R3: counter writes never reach the readable counter directly
  p_cnt_hold_r3: assert property (@(posedge clk) disable iff (rst)
    (host_wr && host_addr == A_LO) |=> (rimg[LOC_CNT_LO] == $past(rimg[LOC_CNT_LO])));

  // R5: quiet bus reset keeps a low line low
  p_bus_rst_quiet_r5: assert property (@(posedge clk) disable iff (rst)
    (cmd_go && act.bus_rst && wimg[LOC_CFG1][CFG1_QUIET_BIT] && !irq && !done_valid)
      |=> !irq);

  // R7: message accepted raises the line
  p_msg_ok_raise_r7: assert property (@(posedge clk) disable iff (rst)
    (cmd_go && act.msg_ok) |=> irq);

  // R10: completion loads the cause and raises the line unless chip reset
  p_done_load_r10: assert property (@(posedge clk) disable iff (rst)
    (done_valid && !(cmd_go && act.chip_rst))
      |=> (irq && rimg[LOC_CAUSE] == $past(done_intr)));

  // R8: chip reset drops the line and DMA mode
  p_chip_rst_r8: assert property (@(posedge clk) disable iff (rst)
    (cmd_go && act.chip_rst) |=> (!irq && !dma_mode));

  // R13: the line and the readable status bit agree
  p_irq_matches_stat_r13: assert property (@(posedge clk) disable iff (rst)
    irq == rimg[LOC_STAT][STAT_IRQ_BIT]);

endmodule

// File: rtl/scsi_cmd_regs.sv
module scsi_cmd_regs
  import scsi_cmd_pkg::*;
#(
  parameter int unsigned DW   = 8,
  parameter int unsigned AW   = 4,
  parameter int unsigned SEQW = 3
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            host_wr,
  input  logic            host_rd,
  input  logic [AW-1:0]   host_addr,
  input  logic [DW-1:0]   host_wdata,
  input  logic            done_valid,
  input  logic [DW-2:0]   done_stat,
  input  logic [DW-1:0]   done_intr,
  input  logic [SEQW-1:0] done_seq,
  output logic [DW-1:0]   host_rdata,
  output logic            irq,
  output logic            dma_mode,
  output logic            xfer_go,
  output logic            sel_go,
  output logic [1:0]      sel_kind
);

  localparam logic [AW-1:0] A_CMD = AW'(LOC_CMD);

  logic    cmd_go;
  action_t act;

  assign cmd_go = host_wr && (host_addr == A_CMD);

  scsi_cmd_decode u_decode (
    .opcode (host_wdata[6:0]),
    .act    (act)
  );

  scsi_reg_bank #(.DW(DW), .AW(AW), .SEQW(SEQW)) u_bank (
    .clk        (clk),
    .rst        (rst),
    .host_wr    (host_wr),
    .host_rd    (host_rd),
    .host_addr  (host_addr),
    .host_wdata (host_wdata),
    .cmd_go     (cmd_go),
    .act        (act),
    .done_valid (done_valid),
    .done_stat  (done_stat),
    .done_intr  (done_intr),
    .done_seq   (done_seq),
    .host_rdata (host_rdata),
    .irq        (irq),
    .dma_mode   (dma_mode)
  );

  // one-cycle strobes to the bus-phase and data-movement neighbours
  always_ff @(posedge clk) begin
    if (rst) begin
      xfer_go  <= 1'b0;
      sel_go   <= 1'b0;
      sel_kind <= '0;
    end else begin
      xfer_go <= cmd_go && act.xfer;
      sel_go  <= cmd_go && act.sel;
      if (cmd_go && act.sel) sel_kind <= host_wdata[1:0];
    end
  end

  // R9: a transfer strobe always traces back to a 0x10 command write
  p_xfer_src_r9: assert property (@(posedge clk) disable iff (rst)
    xfer_go |-> $past(host_wr && host_addr == A_CMD && host_wdata[6:0] == 7'h10));

  // R9: a selection strobe carries the low opcode bits of its command
  p_sel_src_r9: assert property (@(posedge clk) disable iff (rst)
    sel_go |-> (sel_kind == $past(host_wdata[1:0]) && $past(cmd_go)));

endmodule

// File: tb/scsi_cmd_regs_test.sv
module scsi_cmd_regs_test;

  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       host_wr = 1'b0;
  logic       host_rd = 1'b0;
  logic [3:0] host_addr = '0;
  logic [7:0] host_wdata = '0;
  logic       done_valid = 1'b0;
  logic [6:0] done_stat = '0;
  logic [7:0] done_intr = '0;
  logic [2:0] done_seq = '0;
  logic [7:0] host_rdata;
  logic       irq, dma_mode, xfer_go, sel_go;
  logic [1:0] sel_kind;

  int n_run = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  scsi_cmd_regs uut (
    .clk(clk), .rst(rst), .host_wr(host_wr), .host_rd(host_rd),
    .host_addr(host_addr), .host_wdata(host_wdata), .done_valid(done_valid),
    .done_stat(done_stat), .done_intr(done_intr), .done_seq(done_seq),
    .host_rdata(host_rdata), .irq(irq), .dma_mode(dma_mode),
    .xfer_go(xfer_go), .sel_go(sel_go), .sel_kind(sel_kind)
  );

  task automatic check(input string tag, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    host_wr = 1'b1; host_addr = a; host_wdata = d;
    @(negedge clk);
    host_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk);
    host_rd = 1'b1; host_addr = a;
    @(negedge clk);
    host_rd = 1'b0;
    d = host_rdata;
  endtask

  task automatic done(input logic [6:0] s, input logic [7:0] i, input logic [2:0] q);
    @(negedge clk);
    done_valid = 1'b1; done_stat = s; done_intr = i; done_seq = q;
    @(negedge clk);
    done_valid = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1: reset image of every location
    check("R1 irq", irq, 0);
    check("R1 dma_mode", dma_mode, 0);
    for (int a = 15; a >= 0; a--) begin
      rd(4'(a), v);
      check($sformatf("R1 loc %0d", a), v, (a == 8) ? 8'h07 : (a == 14) ? 8'h04 : 8'h00);
    end

    // Opcode sweep over a distinctive preload (R5..R12, R13)
    for (int op = 0; op < 128; op++) begin
      logic [7:0] st, it, sq, fl, cm;
      logic xg, sg;
      logic [1:0] sk;
      string tg;
      wr(4'd3, 8'h02);
      wr(4'd3, 8'h11);
      done(7'h15, 8'h44, 3'd3);
      wr(4'd3, 8'(op));
      xg = xfer_go; sg = sel_go; sk = sel_kind;
      st = 8'h95; it = 8'h44; sq = 8'h03; fl = 8'h02; cm = 8'(op);
      case (op)
        8'h01: begin it = 8'h08; sq = 0; fl = 0; tg = "R6"; end
        8'h02: begin st = 0; it = 0; sq = 0; fl = 0; cm = 0; tg = "R8"; end
        8'h03: begin it = 8'h80; tg = "R5"; end
        8'h10: tg = "R9";
        8'h11: begin st = 8'h97; it = 8'h08; tg = "R12"; end
        8'h12: begin it = 8'h20; sq = 0; fl = 0; tg = "R7"; end
        8'h18: begin st = 8'h90; it = 8'h08; sq = 0; tg = "R12"; end
        8'h41, 8'h42, 8'h43: tg = "R9";
        8'h44: begin it = 0; tg = "R12"; end
        default: tg = "R11";
      endcase
      check($sformatf("%s xfer op %0h", tg, op), xg, op == 8'h10);
      check($sformatf("%s sel op %0h", tg, op), sg, op >= 8'h41 && op <= 8'h43);
      if (op >= 8'h41 && op <= 8'h43)
        check($sformatf("R9 kind op %0h", op), sk, op & 3);
      check($sformatf("R13 irq op %0h", op), irq, st[7]);
      rd(4'd3, v); check($sformatf("%s cmd op %0h", tg, op), v, cm);
      rd(4'd4, v); check($sformatf("%s stat op %0h", tg, op), v, st);
      rd(4'd6, v); check($sformatf("%s step op %0h", tg, op), v, sq);
      rd(4'd7, v); check($sformatf("%s flags op %0h", tg, op), v, fl);
      rd(4'd5, v); check($sformatf("%s cause op %0h", tg, op), v, it);
    end

    // R5: quiet bit masks the interrupt, clear bit lets it through
    wr(4'd3, 8'h02);
    wr(4'd8, 8'h47);
    wr(4'd3, 8'h03);
    check("R5 quiet irq", irq, 0);
    rd(4'd5, v); check("R5 quiet cause", v, 8'h80);
    wr(4'd8, 8'h07);
    wr(4'd3, 8'h03);
    check("R5 loud irq", irq, 1);

    // R2 / R3: counter reload and terminal-count clearing
    wr(4'd3, 8'h02);
    done(7'h10, 8'h00, 3'd0);
    wr(4'd0, 8'h34);
    rd(4'd4, v); check("R3 tc cleared", v, 8'h80);
    rd(4'd0, v); check("R3 lo held", v, 8'h00);
    wr(4'd1, 8'h12);
    rd(4'd1, v); check("R3 mid held", v, 8'h00);
    wr(4'd3, 8'h80);
    check("R2 dma on", dma_mode, 1);
    rd(4'd0, v); check("R2 lo reload", v, 8'h34);
    rd(4'd1, v); check("R2 mid reload", v, 8'h12);
    wr(4'd0, 8'h56);
    rd(4'd0, v); check("R3 lo held after dma", v, 8'h34);
    wr(4'd3, 8'h00);
    check("R2 dma off", dma_mode, 0);
    rd(4'd0, v); check("R2 no reload", v, 8'h34);
    wr(4'd3, 8'h81);
    rd(4'd0, v); check("R2 reload with flush", v, 8'h56);
    rd(4'd5, v); check("R2 flush cause", v, 8'h08);
    wr(4'd3, 8'h82);
    check("R8 dma cleared", dma_mode, 0);

    // R4: read-to-clear of the cause
    wr(4'd3, 8'h11);
    done(7'h15, 8'h44, 3'd3);
    rd(4'd5, v); check("R4 old cause", v, 8'h44);
    check("R4 irq low", irq, 0);
    rd(4'd5, v); check("R4 cause cleared", v, 8'h00);
    rd(4'd4, v); check("R4 stat", v, 8'h05);
    rd(4'd6, v); check("R4 step", v, 8'h04);

    // R14: mirrored versus write-only locations
    wr(4'd3, 8'h02);
    for (int a = 0; a < 16; a++)
      if (a != 3) wr(4'(a), 8'(8'h30 + a));
    for (int a = 15; a >= 0; a--) begin
      logic [7:0] e;
      if (a == 3) continue;
      if (a == 8 || a >= 11) e = 8'(8'h30 + a);
      else e = 8'h00;
      rd(4'(a), v);
      check($sformatf("R14 loc %0d", a), v, e);
    end

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule